// File: doc/BRIEF.md
# Scaled-Index Load/Store Unit

This unit carries out memory loads and stores whose address is a base register value plus an index register value shifted left by zero to three bit positions. A decoder hands it one request at a time: the direction, the access size and signedness, the base and index values, the shift, the three register numbers involved, whether the instruction is conditional and whether it closes its conditional block, and the data to store. The unit checks the register and type combination, forms and checks the address, runs one transfer on a 32-bit little-endian memory port, and returns either a value to write back or a branch target.

Loads shift the addressed byte or halfword down to bit 0 and widen it to 32 bits with zeros or with copies of its top bit. A word load whose destination is the program counter becomes a branch to the loaded value with bit 0 cleared. The loaded bit 0 must be set, which requests the halfword instruction encoding. If it is clear, the unit reports a fault instead. Requests that break the register rules, and requests that are not naturally aligned, finish at once with a flag and do not touch memory.

Top module: `lsu_regoff`

## Requirements
- R1: The memory address is `req_base + (req_index << req_shift)` taken modulo 2^32, with a shift of 0 to 3.
- R2: A store puts its low byte on all four byte lanes with `mem_be = 1 << addr[1:0]`, its low halfword on both halves with `mem_be = 2'b11 << addr[1:0]`, or its full word with `mem_be = 4'hF`. `mem_we` is 1 for a store and 0 for a load. The kind codes are 0 unsigned byte, 1 signed byte, 2 unsigned halfword, 3 signed halfword and 4 word.
- R3: A load takes the byte at lane `addr[1:0]`, or the halfword at lanes `addr[1:0]` and `addr[1:0]+1`. It zero-extends the result for kinds 0 and 2 and sign-extends it for kinds 1 and 3.
- R4: A store of kind 1 or 3, and any request with a kind code of 5 to 7, raises `illegal`.
- R5: A base register of 15, or an index register of 13 or 15, raises `illegal`.
- R6: Data register 13 is accepted only for word loads and word stores. Data register 15 is accepted only for word loads. Any other use of either raises `illegal`.
- R7: When a word load into register 15 returns data with bit 0 set, the unit raises `branch_valid` with `result` equal to that data with bit 0 cleared, and it does not raise `wb_valid`.
- R8: When a word load into register 15 returns data with bit 0 clear, the unit raises `pc_fault` and neither `branch_valid` nor `wb_valid`.
- R9: A word load into register 15 with `req_cond` high and `req_it_last` low raises `illegal`. With `req_it_last` high it is accepted.
- R10: A halfword address with bit 0 set, or a word address with either of bits [1:0] set, raises `align_fault` and issues no memory request. When a request is both illegal and misaligned, only `illegal` is raised.
- R11: `req_ready` is high only when the unit is idle. `mem_req_valid` and its address stay stable until `mem_req_ready`. `req_valid` is ignored while the unit is busy. `done` pulses one cycle after `mem_rsp_valid`, or one cycle after acceptance for a request that is rejected.
- R12: On a completed load that is not a program-counter load, `wb_valid` pulses with `done`, and `wb_reg` equals the data register number of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| req_is_load | input | 1 | 1 load, 0 store |
| req_kind | input | 3 | Access kind code (see R2) |
| req_base | input | 32 | Base register value |
| req_index | input | 32 | Index register value |
| req_shift | input | 2 | Left shift applied to the index |
| req_rt | input | 4 | Data register number |
| req_rn | input | 4 | Base register number |
| req_rm | input | 4 | Index register number |
| req_cond | input | 1 | Instruction is conditional |
| req_it_last | input | 1 | Instruction is last in its conditional block |
| req_store_data | input | 32 | Data to store |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rsp_valid | input | 1 | Response (read data or write acknowledge) |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Request finished (one-cycle pulse) |
| wb_valid | output | 1 | `result` is a register writeback |
| branch_valid | output | 1 | `result` is a branch target |
| result | output | 32 | Writeback value or branch target |
| wb_reg | output | 4 | Destination register of the finished request |
| illegal | output | 1 | Register/kind combination rejected |
| align_fault | output | 1 | Misaligned address rejected |
| pc_fault | output | 1 | Program-counter load returned an even value |

## Verification
The assertions assume that memory raises `mem_rsp_valid` only after a request has been accepted, never while it is still pending and never twice for one transfer. They also assume that `mem_req_ready` is asserted only while `mem_req_valid` is high. The bench's memory model follows both rules. It waits a per-vector number of stall cycles with ready low, gives one ready pulse, and then returns one response a cycle later. The request inputs may change freely while the unit is busy, and one directed case does exactly that to show those inputs are ignored.

// File: rtl/lsu_regoff_pkg.sv
package lsu_regoff_pkg;

    typedef enum logic [2:0] {
        ACC_UBYTE = 3'd0,
        ACC_SBYTE = 3'd1,
        ACC_UHALF = 3'd2,
        ACC_SHALF = 3'd3,
        ACC_WORD  = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } lsu_state_e;

    localparam int unsigned REG_STACK = 13;
    localparam int unsigned REG_PROG  = 15;

    function automatic logic is_byte_kind(input acc_kind_e k);
        return (k == ACC_UBYTE) || (k == ACC_SBYTE);
    endfunction

    function automatic logic is_half_kind(input acc_kind_e k);
        return (k == ACC_UHALF) || (k == ACC_SHALF);
    endfunction

endpackage

// File: rtl/lsu_regoff_agen.sv
module lsu_regoff_agen
    import lsu_regoff_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SHIFT_W = 2,
    parameter int LO_W    = 2
) (
    input  acc_kind_e          kind,
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W-1:0]  index,
    input  logic [SHIFT_W-1:0] shift,
    output logic [ADDR_W-1:0]  addr,
    output logic               misaligned
);
    logic [ADDR_W-1:0] scaled;

    always_comb begin
        scaled = index << shift;
        addr   = base + scaled;
        if (is_half_kind(kind)) begin
            misaligned = addr[0];
        end else if (kind == ACC_WORD) begin
            misaligned = |addr[LO_W-1:0];
        end else begin
            misaligned = 1'b0;
        end
    end
endmodule

// File: rtl/lsu_regoff_legal.sv
module lsu_regoff_legal
    import lsu_regoff_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic             is_load,
    input  acc_kind_e        kind,
    input  logic [REG_W-1:0] rt,
    input  logic [REG_W-1:0] rn,
    input  logic [REG_W-1:0] rm,
    input  logic             cond,
    input  logic             it_last,
    output logic             bad
);
    logic kind_ok, signed_store, base_bad, index_bad, sp_bad, pc_bad, it_bad;
    logic word_load;

    always_comb begin
        kind_ok      = (kind == ACC_UBYTE) || (kind == ACC_SBYTE) || (kind == ACC_UHALF)
                    || (kind == ACC_SHALF) || (kind == ACC_WORD);
        signed_store = !is_load && ((kind == ACC_SBYTE) || (kind == ACC_SHALF));
        base_bad     = (rn == REG_W'(REG_PROG));
        index_bad    = (rm == REG_W'(REG_PROG)) || (rm == REG_W'(REG_STACK));
        word_load    = is_load && (kind == ACC_WORD);
        sp_bad       = (rt == REG_W'(REG_STACK)) && (kind != ACC_WORD);
        pc_bad       = (rt == REG_W'(REG_PROG)) && !word_load;
        it_bad       = (rt == REG_W'(REG_PROG)) && word_load && cond && !it_last;
        bad = !kind_ok || signed_store || base_bad || index_bad || sp_bad || pc_bad || it_bad;
    end
endmodule

// File: rtl/lsu_regoff_lanes.sv
module lsu_regoff_lanes
    import lsu_regoff_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int LO_W   = $clog2(LANES)
) (
    input  acc_kind_e         kind,
    input  logic [LO_W-1:0]   addr_lo,
    input  logic [DATA_W-1:0] sdata,
    input  logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ldata
);
    logic k_byte, k_half;
    assign k_byte = is_byte_kind(kind);
    assign k_half = is_half_kind(kind);

    // Store side: one generate lane per byte of the bus.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be[g] = k_byte ? (addr_lo == LO_W'(g))
                     : k_half ? (addr_lo[LO_W-1:1] == (LO_W-1)'(g / 2))
                     : 1'b1;
        assign wdata[g*8 +: 8] = k_byte ? sdata[7:0]
                               : k_half ? sdata[(g % 2)*8 +: 8]
                               : sdata[g*8 +: 8];
    end

    // Load side: move the addressed field to bit 0, then widen.
    logic [DATA_W-1:0] byte_dn, half_dn;
    always_comb begin
        byte_dn = rdata >> {addr_lo, 3'b000};
        half_dn = rdata >> {addr_lo[LO_W-1:1], 4'b0000};
        case (kind)
            ACC_UBYTE: ldata = {{(DATA_W-8){1'b0}}, byte_dn[7:0]};
            ACC_SBYTE: ldata = {{(DATA_W-8){byte_dn[7]}}, byte_dn[7:0]};
            ACC_UHALF: ldata = {{(DATA_W-16){1'b0}}, half_dn[15:0]};
            ACC_SHALF: ldata = {{(DATA_W-16){half_dn[15]}}, half_dn[15:0]};
            default:   ldata = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_regoff.sv
module lsu_regoff
    import lsu_regoff_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int REG_W   = 4,
    parameter int SHIFT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_load,
    input  logic [2:0]        req_kind,
    input  logic [DATA_W-1:0] req_base,
    input  logic [DATA_W-1:0] req_index,
    input  logic [SHIFT_W-1:0] req_shift,
    input  logic [REG_W-1:0]  req_rt,
    input  logic [REG_W-1:0]  req_rn,
    input  logic [REG_W-1:0]  req_rm,
    input  logic              req_cond,
    input  logic              req_it_last,
    input  logic [DATA_W-1:0] req_store_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              wb_valid,
    output logic              branch_valid,
    output logic [DATA_W-1:0] result,
    output logic [REG_W-1:0]  wb_reg,
    output logic              illegal,
    output logic              align_fault,
    output logic              pc_fault
);
    localparam int LANES = DATA_W / 8;
    localparam int LO_W  = $clog2(LANES);

    typedef struct packed {
        lsu_state_e        st;
        logic [DATA_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic              we;
        logic [DATA_W-1:0] wdata;
        acc_kind_e         kind;
        logic [REG_W-1:0]  rt;
        logic              done;
        logic              wb_v;
        logic              br_v;
        logic              ill;
        logic              alf;
        logic              pcf;
        logic [DATA_W-1:0] res;
    } ctx_t;

    ctx_t q, d;

    acc_kind_e         in_kind;
    logic [DATA_W-1:0] ea;
    logic              ea_mis, rule_bad;
    logic [LANES-1:0]  st_be;
    logic [DATA_W-1:0] st_wdata, in_ldata_unused;
    logic [LANES-1:0]  rd_be_unused;
    logic [DATA_W-1:0] rd_wdata_unused, ld_val;

    assign in_kind = acc_kind_e'(req_kind);

    lsu_regoff_agen #(.ADDR_W(DATA_W), .SHIFT_W(SHIFT_W), .LO_W(LO_W)) i_agen (
        .kind(in_kind), .base(req_base), .index(req_index), .shift(req_shift),
        .addr(ea), .misaligned(ea_mis)
    );

    lsu_regoff_legal #(.REG_W(REG_W)) i_legal (
        .is_load(req_is_load), .kind(in_kind), .rt(req_rt), .rn(req_rn), .rm(req_rm),
        .cond(req_cond), .it_last(req_it_last), .bad(rule_bad)
    );

    // Store lane steering for the incoming request.
    lsu_regoff_lanes #(.DATA_W(DATA_W)) i_st_lanes (
        .kind(in_kind), .addr_lo(ea[LO_W-1:0]), .sdata(req_store_data), .rdata(mem_rdata),
        .be(st_be), .wdata(st_wdata), .ldata(in_ldata_unused)
    );

    // Load alignment for the access in flight.
    lsu_regoff_lanes #(.DATA_W(DATA_W)) i_ld_lanes (
        .kind(q.kind), .addr_lo(q.addr[LO_W-1:0]), .sdata(q.wdata), .rdata(mem_rdata),
        .be(rd_be_unused), .wdata(rd_wdata_unused), .ldata(ld_val)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.wb_v = 1'b0;
        d.br_v = 1'b0;
        d.ill  = 1'b0;
        d.alf  = 1'b0;
        d.pcf  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.rt = req_rt;
                    if (rule_bad) begin
                        d.done = 1'b1;
                        d.ill  = 1'b1;
                    end else if (ea_mis) begin
                        d.done = 1'b1;
                        d.alf  = 1'b1;
                    end else begin
                        d.st    = ST_ISSUE;
                        d.addr  = ea;
                        d.be    = st_be;
                        d.we    = !req_is_load;
                        d.wdata = st_wdata;
                        d.kind  = in_kind;
                    end
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    if (!q.we) begin
                        if (q.rt == REG_W'(REG_PROG)) begin
                            if (ld_val[0]) begin
                                d.br_v = 1'b1;
                                d.res  = {ld_val[DATA_W-1:1], 1'b0};
                            end else begin
                                d.pcf  = 1'b1;
                                d.res  = ld_val;
                            end
                        end else begin
                            d.wb_v = 1'b1;
                            d.res  = ld_val;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign mem_req_valid = (q.st == ST_ISSUE);
    assign mem_we        = q.we;
    assign mem_addr      = q.addr;
    assign mem_be        = q.be;
    assign mem_wdata     = q.wdata;
    assign done          = q.done;
    assign wb_valid      = q.wb_v;
    assign branch_valid  = q.br_v;
    assign result        = q.res;
    assign wb_reg        = q.rt;
    assign illegal       = q.ill;
    assign align_fault   = q.alf;
    assign pc_fault      = q.pcf;

    // A stalled memory request keeps its address and lanes.
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) && $stable(mem_be));

    // The unit never advertises readiness while a memory access is pending.
    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // Branch targets are halfword aligned.
    assert_branch_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
        branch_valid |-> !result[0]);

    // At most one outcome per completion, and none without done (R8, R10).
    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_valid, branch_valid, illegal, align_fault, pc_fault}));
    assert_flags_need_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid || branch_valid || illegal || align_fault || pc_fault) |-> done);

    // Lane enables on the bus are one byte, one halfword, or the whole word.
    assert_lane_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                           || $countones(mem_be) == LANES));

    // Full-word enables only on aligned addresses.
    assert_word_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && (&mem_be) |-> (mem_addr[LO_W-1:0] == '0));

    // Signed byte loads return a properly widened value.
    assert_sbyte_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && (q.kind == ACC_SBYTE) |-> (result[DATA_W-1:8] == {(DATA_W-8){result[7]}}));
endmodule

// File: tb/test_lsu_regoff.sv
module test_lsu_regoff;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 29;

    localparam logic [2:0] O_ST = 3'd0, O_WB = 3'd1, O_BR = 3'd2,
                           O_ILL = 3'd3, O_ALN = 3'd4, O_PCF = 3'd5;
    localparam logic [2:0] K_UB = 3'd0, K_SB = 3'd1, K_UH = 3'd2, K_SH = 3'd3, K_W = 3'd4;
    localparam logic [31:0] RD = 32'h8A7F_C3E5;

    typedef struct packed {
        logic [23:0] tag;
        logic        ld;
        logic [2:0]  kind;
        logic [31:0] base;
        logic [31:0] idx;
        logic [1:0]  sh;
        logic [3:0]  rt;
        logic [3:0]  rn;
        logic [3:0]  rm;
        logic        cond;
        logic        last;
        logic [31:0] sdata;
        logic [31:0] rdata;
        logic [2:0]  outc;
        logic [31:0] eaddr;
        logic [3:0]  ebe;
        logic [31:0] eval;
    } vec_t;

    function automatic vec_t mk(
        input logic [23:0] tag, input logic ld, input logic [2:0] kind,
        input logic [31:0] base, input logic [31:0] idx, input logic [1:0] sh,
        input logic [3:0] rt, input logic [3:0] rn, input logic [3:0] rm,
        input logic cond, input logic last, input logic [31:0] sdata, input logic [31:0] rdata,
        input logic [2:0] outc, input logic [31:0] eaddr, input logic [3:0] ebe,
        input logic [31:0] eval);
        vec_t v;
        v = '{tag, ld, kind, base, idx, sh, rt, rn, rm, cond, last, sdata, rdata,
              outc, eaddr, ebe, eval};
        return v;
    endfunction

    localparam vec_t VECS [NV] = '{
        mk("R1 ", 1, K_W,  32'h1000, 32'h4, 2, 2, 1, 3, 0, 0, 0, RD, O_WB, 32'h1010, 4'hF, RD),
        mk("R3 ", 1, K_UB, 32'h2000, 32'h3, 0, 2, 1, 3, 0, 0, 0, RD, O_WB, 32'h2003, 4'h8, 32'h0000_008A),
        mk("R3 ", 1, K_SB, 32'h2000, 32'h1, 0, 2, 1, 3, 0, 0, 0, RD, O_WB, 32'h2001, 4'h2, 32'hFFFF_FFC3),
        mk("R3 ", 1, K_SB, 32'h2000, 32'h1, 1, 2, 1, 3, 0, 0, 0, RD, O_WB, 32'h2002, 4'h4, 32'h0000_007F),
        mk("R3 ", 1, K_UH, 32'h3000, 32'h1, 1, 2, 1, 3, 0, 0, 0, RD, O_WB, 32'h3002, 4'hC, 32'h0000_8A7F),
        mk("R3 ", 1, K_SH, 32'h3000, 32'h0, 0, 2, 1, 3, 0, 0, 0, RD, O_WB, 32'h3000, 4'h3, 32'hFFFF_C3E5),
        mk("R3 ", 1, K_SH, 32'h3000, 32'h2, 0, 2, 1, 3, 0, 0, 0, RD, O_WB, 32'h3002, 4'hC, 32'hFFFF_8A7F),
        mk("R2 ", 0, K_UB, 32'h4000, 32'h1, 0, 2, 1, 3, 0, 0, 32'h1234_56AB, RD, O_ST, 32'h4001, 4'h2, 32'hABAB_ABAB),
        mk("R2 ", 0, K_UH, 32'h4000, 32'h1, 1, 2, 1, 3, 0, 0, 32'h1234_CDEF, RD, O_ST, 32'h4002, 4'hC, 32'hCDEF_CDEF),
        mk("R2 ", 0, K_W,  32'h4000, 32'h1, 3, 2, 1, 3, 0, 0, 32'hDEAD_BEEF, RD, O_ST, 32'h4008, 4'hF, 32'hDEAD_BEEF),
        mk("R7 ", 1, K_W,  32'h5000, 32'h0, 0, 15, 1, 3, 0, 0, 0, RD, O_BR, 32'h5000, 4'hF, 32'h8A7F_C3E4),
        mk("R8 ", 1, K_W,  32'h5000, 32'h4, 0, 15, 1, 3, 0, 0, 0, 32'h1234, O_PCF, 32'h5004, 4'hF, 0),
        mk("R4 ", 0, K_SB, 32'h4000, 32'h0, 0, 2, 1, 3, 0, 0, 0, RD, O_ILL, 0, 0, 0),
        mk("R4 ", 0, K_SH, 32'h4000, 32'h0, 0, 2, 1, 3, 0, 0, 0, RD, O_ILL, 0, 0, 0),
        mk("R5 ", 1, K_W,  32'h1000, 32'h0, 0, 2, 15, 3, 0, 0, 0, RD, O_ILL, 0, 0, 0),
        mk("R5 ", 1, K_W,  32'h1000, 32'h0, 0, 2, 1, 13, 0, 0, 0, RD, O_ILL, 0, 0, 0),
        mk("R5 ", 1, K_W,  32'h1000, 32'h0, 0, 2, 1, 15, 0, 0, 0, RD, O_ILL, 0, 0, 0),
        mk("R6 ", 1, K_UB, 32'h2000, 32'h0, 0, 13, 1, 3, 0, 0, 0, RD, O_ILL, 0, 0, 0),
        mk("R6 ", 0, K_W,  32'h4000, 32'h3, 2, 13, 1, 3, 0, 0, 32'h0102_0304, RD, O_ST, 32'h400C, 4'hF, 32'h0102_0304),
        mk("R6 ", 0, K_W,  32'h4000, 32'h0, 0, 15, 1, 3, 0, 0, 0, RD, O_ILL, 0, 0, 0),
        mk("R9 ", 1, K_W,  32'h6000, 32'h1, 2, 15, 1, 3, 1, 0, 0, RD, O_ILL, 0, 0, 0),
        mk("R9 ", 1, K_W,  32'h6000, 32'h1, 2, 15, 1, 3, 1, 1, 0, 32'h8001, O_BR, 32'h6004, 4'hF, 32'h8000),
        mk("R10", 1, K_UH, 32'h3000, 32'h1, 0, 2, 1, 3, 0, 0, 0, RD, O_ALN, 0, 0, 0),
        mk("R10", 1, K_W,  32'h1000, 32'h1, 1, 2, 1, 3, 0, 0, 0, RD, O_ALN, 0, 0, 0),
        mk("R10", 0, K_SH, 32'h3001, 32'h0, 0, 2, 1, 3, 0, 0, 0, RD, O_ILL, 0, 0, 0),
        mk("R1 ", 1, K_W,  32'hFFFF_FFFC, 32'h2, 2, 0, 1, 3, 0, 0, 0, RD, O_WB, 32'h4, 4'hF, RD),
        mk("R1 ", 1, K_W,  32'h0, 32'h2000_0001, 3, 0, 1, 3, 0, 0, 0, RD, O_WB, 32'h8, 4'hF, RD),
        mk("R6 ", 1, K_W,  32'h1000, 32'h0, 0, 13, 1, 3, 0, 0, 0, RD, O_WB, 32'h1000, 4'hF, RD),
        mk("R3 ", 1, K_UB, 32'h2000, 32'h0, 0, 2, 1, 3, 0, 0, 0, RD, O_WB, 32'h2000, 4'h1, 32'h0000_00E5)
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_ready, req_is_load = 0, req_cond = 0, req_it_last = 0;
    logic [2:0] req_kind = 0;
    logic [31:0] req_base = 0, req_index = 0, req_store_data = 0;
    logic [1:0] req_shift = 0;
    logic [3:0] req_rt = 0, req_rn = 0, req_rm = 0;
    logic mem_req_valid, mem_req_ready = 0, mem_we, mem_rsp_valid = 0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = 0, result;
    logic [3:0] mem_be, wb_reg;
    logic done, wb_valid, branch_valid, illegal, align_fault, pc_fault;

    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_regoff i_lsu_regoff (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_load(req_is_load), .req_kind(req_kind), .req_base(req_base),
        .req_index(req_index), .req_shift(req_shift), .req_rt(req_rt), .req_rn(req_rn),
        .req_rm(req_rm), .req_cond(req_cond), .req_it_last(req_it_last),
        .req_store_data(req_store_data), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rdata(mem_rdata), .done(done), .wb_valid(wb_valid),
        .branch_valid(branch_valid), .result(result), .wb_reg(wb_reg),
        .illegal(illegal), .align_fault(align_fault), .pc_fault(pc_fault)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive_req(input vec_t v);
        req_is_load = v.ld;  req_kind = v.kind;  req_base = v.base;  req_index = v.idx;
        req_shift = v.sh;    req_rt = v.rt;      req_rn = v.rn;      req_rm = v.rm;
        req_cond = v.cond;   req_it_last = v.last; req_store_data = v.sdata;
    endtask

    task automatic run_vec(input vec_t v, input int stall, input bit poke);
        string t;
        logic [31:0] held;
        t = string'(v.tag);
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready before request", {31'b0, req_ready}, 1);
        drive_req(v);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (v.outc == O_ILL || v.outc == O_ALN) begin
            chk(done == 1'b1 && mem_req_valid == 1'b0, t, "rejected: done, no memory request",
                {30'b0, done, mem_req_valid}, 32'h2);
        end else begin
            chk(mem_req_valid == 1'b1, "R11", "memory request issued", {31'b0, mem_req_valid}, 1);
            chk(mem_addr == v.eaddr, t, "address (R1)", mem_addr, v.eaddr);
            chk(mem_be == v.ebe, t, "byte enables (R2)", {28'b0, mem_be}, {28'b0, v.ebe});
            chk(mem_we == !v.ld, t, "write strobe (R2)", {31'b0, mem_we}, {31'b0, !v.ld});
            if (!v.ld) chk(mem_wdata == v.eval, t, "write data (R2)", mem_wdata, v.eval);
            held = mem_addr;
            if (poke) begin
                vec_t other;
                other = v;
                other.base = 32'h7700; other.kind = K_W; other.ld = 0;
                drive_req(other);
                req_valid = 1'b1;
            end
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                chk(mem_req_valid && mem_addr == held && !req_ready, "R11",
                    "request held while stalled", mem_addr, held);
            end
            req_valid = 1'b0;
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b1;
            mem_rdata = v.rdata;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            chk(done == 1'b1, "R11", "done one cycle after response", {31'b0, done}, 1);
        end
        chk(illegal == (v.outc == O_ILL), t, "illegal flag", {31'b0, illegal}, {31'b0, v.outc == O_ILL});
        chk(align_fault == (v.outc == O_ALN), t, "align flag", {31'b0, align_fault}, {31'b0, v.outc == O_ALN});
        chk(pc_fault == (v.outc == O_PCF), t, "pc fault flag", {31'b0, pc_fault}, {31'b0, v.outc == O_PCF});
        chk(branch_valid == (v.outc == O_BR), t, "branch flag", {31'b0, branch_valid}, {31'b0, v.outc == O_BR});
        chk(wb_valid == (v.outc == O_WB), t, "writeback flag (R12)", {31'b0, wb_valid}, {31'b0, v.outc == O_WB});
        if (v.outc == O_WB || v.outc == O_BR)
            chk(result == v.eval, t, "result", result, v.eval);
        if (v.outc == O_WB)
            chk(wb_reg == v.rt, "R12", "writeback register", {28'b0, wb_reg}, {28'b0, v.rt});
        if (poke) begin
            @(negedge clk);
            chk(!done && !mem_req_valid, "R11", "request offered while busy was ignored",
                {30'b0, done, mem_req_valid}, 0);
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 3000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_req_valid && !done, "R11", "reset state idle",
            {29'b0, req_ready, mem_req_valid, done}, 32'h4);
        chk(!wb_valid && !branch_valid && !illegal && !align_fault && !pc_fault, "R12",
            "reset state no outcome", {27'b0, wb_valid, branch_valid, illegal, align_fault, pc_fault}, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i % 3, 1'b0);

        // Directed: new request offered during a long stall is ignored (R11).
        run_vec(VECS[0], 4, 1'b1);
        // Directed: a fault followed immediately by a normal load (R10, R3).
        run_vec(VECS[22], 0, 1'b0);
        run_vec(VECS[28], 0, 1'b0);
        // Directed: signed halfword from upper half with zero stall (R3).
        run_vec(VECS[6], 0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule